// File: doc/BRIEF.md
# PC Card attribute memory and CIS responder

This block answers host accesses to the attribute memory space of a PC Card. When the host reads attribute memory, the block returns the bytes of a fixed tuple chain held in an internal ROM. The chain describes the card to the host: device type, product strings, identifiers and one configuration entry that asks for a small 8-bit I/O window. The same space holds a single configuration register. The host writes it during enumeration to move the card out of memory-only operation.

The card starts in memory-only mode. In that mode the four shared status pins present write-protect, ready and battery-state levels. When the host writes a non-zero configuration index, the pins take their I/O-mode meanings instead: 16-bit I/O indication, interrupt request, status change and speaker. All host strobes are sampled once on the block clock. Read data is registered before it reaches the bus, so a read strobe is answered two clock edges after it arrives.

Top module: `pccard_attr_resp`

## Requirements
- R1: While reset is asserted, and after it is released, the block leaves the data bus undriven (`data_oe_o` = 0), holds the configuration index at 0, keeps `io_mode_o` = 0, and drives the shared pins to their memory-mode levels. Those levels are write-protect = 0, ready = 1, battery 1 = 1 and battery 2 = 1.
- R2: An attribute read is REG# low, CE1# low and OE# low. It is answered with `data_oe_o` = 1, and `data_o` holds the ROM byte for offset N when the address is 2·N. Both appear after the second rising clock edge that samples the strobes. CE2# has no effect on the result.
- R3: An attribute read at any odd address returns 0x00.
- R4: ROM offsets 0 to 18 hold, in order, 01 03 D4 00 FF 15 0C 04 01 58 59 5A 00 50 43 43 31 00 FF. These are a device-info tuple followed by a version-1 tuple carrying two null-terminated strings and an 0xFF string terminator.
- R5: ROM offsets 19 to 38 hold, in order, 20 04 FF FF 01 00 1A 05 01 01 00 02 01 1B 04 C1 01 08 26 FF. These are the manufacturer-ID tuple, the configuration tuple (register base 0x0200, mask 0x01), the table entry and the end-of-chain byte. In the table entry, 0xC1 means default, interface and index 1. 0x26 means 6 I/O address lines with 8-bit data.
- R6: An even-address attribute read beyond offset 38, other than address 0x200, returns 0xFF. This includes offsets past the end of the ROM.
- R7: `data_oe_o` returns to 0 by the second rising edge after OE# goes high. A read with REG# high, or with CE1# high, never drives the bus.
- R8: A write is REG# low, CE1# low, WE# low and OE# high at address 0x200. It stores `data_i[5:0]` as the configuration index. An attribute read at 0x200 returns the index in bits 5:0, with bits 7:6 equal to 0.
- R9: A write at any address other than 0x200, or a write with REG# high, leaves the configuration index unchanged.
- R10: A non-zero configuration index sets `io_mode_o` = 1 and drives all four shared pins to 1: IOIS16# inactive, no interrupt, no status change, speaker off. Writing index 0 returns the card to the memory-mode levels of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; host strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| addr_i | input | 26 | Host address |
| ce1_n_i | input | 1 | Card enable, low byte lane, active low |
| ce2_n_i | input | 1 | Card enable, high byte lane, active low (does not affect attribute accesses) |
| oe_n_i | input | 1 | Output enable (read strobe), active low |
| we_n_i | input | 1 | Write enable, active low |
| reg_n_i | input | 1 | Attribute space select, active low |
| data_i | input | 8 | Low byte of the host data bus, as seen by the card |
| data_o | output | 8 | Byte the card drives onto the low data lanes |
| data_oe_o | output | 1 | Drive enable for `data_o` |
| wp_iois16_n_o | output | 1 | Write-protect in memory mode, IOIS16# in I/O mode |
| ready_ireq_n_o | output | 1 | Ready in memory mode, IREQ# in I/O mode |
| bvd1_stschg_n_o | output | 1 | Battery 1 in memory mode, STSCHG# in I/O mode |
| bvd2_spkr_n_o | output | 1 | Battery 2 in memory mode, SPKR# in I/O mode |
| io_mode_o | output | 1 | High while the configuration index is non-zero |

## Verification
The bench reads every ROM offset through its even address. This catches a design that indexes the ROM with the raw byte address: such a design would return the chain compressed or shifted. The bench also reads odd addresses and several addresses past the chain, including one just below the configuration register. A decode that ignored address bit 0, or read past the ROM into undefined bytes, would return tuple data or garbage where 0x00 or 0xFF is required. Writes with the upper data bits set check that only six bits are kept. Writes to a neighbouring address, or with REG# high, must leave the mode alone; a loose decode would flip the status pins. Reset is applied while I/O mode is active, to catch a configuration register that survives reset.

// File: rtl/pccard_attr_pkg.sv
package pccard_attr_pkg;

  localparam int unsigned HOST_ADDR_W = 26;
  localparam int unsigned CHAIN_LEN   = 39;
  localparam logic [7:0]  FILL_BYTE   = 8'hFF;
  localparam logic [7:0]  ODD_BYTE    = 8'h00;

  // Tuple chain content by table offset; the host reads offset N at 2*N.
  function automatic logic [7:0] cis_byte(input int unsigned ofs);
    case (ofs)
      // device information: function specific, 100 ns, one 512-byte unit
      0: return 8'h01;  1: return 8'h03;  2: return 8'hD4;  3: return 8'h00;
      4: return 8'hFF;
      // version 1 product information with two strings
      5: return 8'h15;  6: return 8'h0C;  7: return 8'h04;  8: return 8'h01;
      9: return 8'h58; 10: return 8'h59; 11: return 8'h5A; 12: return 8'h00;
      13: return 8'h50; 14: return 8'h43; 15: return 8'h43; 16: return 8'h31;
      17: return 8'h00; 18: return 8'hFF;
      // manufacturer and card identifiers
      19: return 8'h20; 20: return 8'h04; 21: return 8'hFF; 22: return 8'hFF;
      23: return 8'h01; 24: return 8'h00;
      // configuration: base 0x0200, only register 0 present
      25: return 8'h1A; 26: return 8'h05; 27: return 8'h01; 28: return 8'h01;
      29: return 8'h00; 30: return 8'h02; 31: return 8'h01;
      // table entry: index 1, 64-byte 8-bit I/O window
      32: return 8'h1B; 33: return 8'h04; 34: return 8'hC1; 35: return 8'h01;
      36: return 8'h08; 37: return 8'h26;
      // end of chain
      38: return 8'hFF;
      default: return FILL_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/cis_rom.sv
module cis_rom import pccard_attr_pkg::*; #(
  parameter int unsigned OFS_W     = HOST_ADDR_W - 1,
  parameter int unsigned ROM_DEPTH = 64
) (
  input  logic [OFS_W-1:0] ofs_i,
  output logic [7:0]       byte_o
);

  localparam int unsigned IDX_W = $clog2(ROM_DEPTH);

  logic [7:0] rom_w [ROM_DEPTH];

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
    assign rom_w[g] = cis_byte(g);
  end

  always_comb begin
    if (ofs_i < OFS_W'(ROM_DEPTH)) byte_o = rom_w[ofs_i[IDX_W-1:0]];
    else                           byte_o = FILL_BYTE;
  end

endmodule

// File: rtl/attr_host_if.sv
module attr_host_if import pccard_attr_pkg::*; #(
  parameter int unsigned       ADDR_W   = HOST_ADDR_W,
  parameter logic [ADDR_W-1:0] COR_ADDR = ADDR_W'('h200),
  parameter int unsigned       IDX_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce1_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic              reg_n_i,
  input  logic [IDX_W-1:0]  din_i,
  output logic [ADDR_W-2:0] rom_ofs_o,
  input  logic [7:0]        rom_byte_i,
  input  logic [IDX_W-1:0]  cfg_i,
  output logic              cor_wr_o,
  output logic [IDX_W-1:0]  cor_wdata_o,
  output logic [7:0]        dout_o,
  output logic              doe_o
);

  logic [ADDR_W-1:0] addr_q;
  logic              ce1_q, oe_q, we_q, reg_q;
  logic [IDX_W-1:0]  din_q;
  logic              acc_hit, rd_hit, cor_hit;
  logic [7:0]        dout_d, dout_q;
  logic              doe_d, doe_q;

  // stage 1: host strobes, address and data sampled on the block clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ce1_q  <= 1'b1;
      oe_q   <= 1'b1;
      we_q   <= 1'b1;
      reg_q  <= 1'b1;
      din_q  <= '0;
    end else begin
      addr_q <= addr_i;
      ce1_q  <= ce1_n_i;
      oe_q   <= oe_n_i;
      we_q   <= we_n_i;
      reg_q  <= reg_n_i;
      din_q  <= din_i;
    end
  end

  // decode of the sampled access
  always_comb begin
    acc_hit     = !reg_q && !ce1_q;
    rd_hit      = acc_hit && !oe_q;
    cor_hit     = (addr_q == COR_ADDR);
    cor_wr_o    = acc_hit && !we_q && oe_q && cor_hit;
    cor_wdata_o = din_q;
    rom_ofs_o   = addr_q[ADDR_W-1:1];
  end

  // read data selection
  always_comb begin
    if (cor_hit)        dout_d = 8'(cfg_i);
    else if (addr_q[0]) dout_d = ODD_BYTE;
    else                dout_d = rom_byte_i;
    doe_d = rd_hit;
  end

  // stage 2: registered bus drive, data loaded only on a read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      doe_q  <= 1'b0;
    end else begin
      doe_q <= doe_d;
      if (rd_hit) dout_q <= dout_d;
    end
  end

  assign dout_o = dout_q;
  assign doe_o  = doe_q;

  // R7: a sampled high OE# removes the drive at the next edge
  a_r7_release_on_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |=> !doe_o);

  // R3: a driven answer to an odd address carries no tuple data
  a_r3_odd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (doe_o && $past(addr_q[0])) |-> (dout_o == ODD_BYTE));

endmodule

// File: rtl/cor_reg.sv
module cor_reg #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wdata_i,
  output logic [IDX_W-1:0] cfg_o,
  output logic             io_mode_o
);

  logic [IDX_W-1:0] cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_i) cfg_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o     = cfg_q;
  assign io_mode_o = (cfg_q != '0);

  // R8: a register write is visible on the next edge
  a_r8_index_latched: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cfg_o == $past(wdata_i)));

  // R9: without a register write the index holds
  a_r9_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(cfg_o));

endmodule

// File: rtl/status_pin_mux.sv
module status_pin_mux #(
  parameter int unsigned      NPINS   = 4,
  parameter logic [NPINS-1:0] MEM_LVL = 4'b1110,
  parameter logic [NPINS-1:0] IO_LVL  = 4'b1111
) (
  input  logic             io_mode_i,
  output logic [NPINS-1:0] pins_o
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign pins_o[p] = io_mode_i ? IO_LVL[p] : MEM_LVL[p];
  end

endmodule

// File: rtl/pccard_attr_resp.sv
module pccard_attr_resp import pccard_attr_pkg::*; #(
  parameter int unsigned       ADDR_W    = HOST_ADDR_W,
  parameter int unsigned       ROM_DEPTH = 64,
  parameter int unsigned       IDX_W     = 6,
  parameter logic [ADDR_W-1:0] COR_ADDR  = ADDR_W'('h200)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce1_n_i,
  input  logic              ce2_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic              reg_n_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              wp_iois16_n_o,
  output logic              ready_ireq_n_o,
  output logic              bvd1_stschg_n_o,
  output logic              bvd2_spkr_n_o,
  output logic              io_mode_o
);

  localparam int unsigned NPINS = 4;

  logic [1:0]        rst_sync_q;
  logic              rst_i;
  logic [ADDR_W-2:0] rom_ofs;
  logic [7:0]        rom_byte;
  logic [IDX_W-1:0]  cfg;
  logic              cor_wr;
  logic [IDX_W-1:0]  cor_wdata;
  logic [NPINS-1:0]  pin_v;
  logic              unused_pins;

  // byte-lane enable for the high lanes and the top data bits play no part
  assign unused_pins = ce2_n_i ^ (^data_i[7:IDX_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  attr_host_if #(.ADDR_W(ADDR_W), .COR_ADDR(COR_ADDR), .IDX_W(IDX_W)) i_host (
    .clk        (clk),
    .rst_n      (rst_i),
    .addr_i     (addr_i),
    .ce1_n_i    (ce1_n_i),
    .oe_n_i     (oe_n_i),
    .we_n_i     (we_n_i),
    .reg_n_i    (reg_n_i),
    .din_i      (data_i[IDX_W-1:0]),
    .rom_ofs_o  (rom_ofs),
    .rom_byte_i (rom_byte),
    .cfg_i      (cfg),
    .cor_wr_o   (cor_wr),
    .cor_wdata_o(cor_wdata),
    .dout_o     (data_o),
    .doe_o      (data_oe_o)
  );

  cis_rom #(.OFS_W(ADDR_W - 1), .ROM_DEPTH(ROM_DEPTH)) i_rom (
    .ofs_i (rom_ofs),
    .byte_o(rom_byte)
  );

  cor_reg #(.IDX_W(IDX_W)) i_cor (
    .clk      (clk),
    .rst_n    (rst_i),
    .wr_i     (cor_wr),
    .wdata_i  (cor_wdata),
    .cfg_o    (cfg),
    .io_mode_o(io_mode_o)
  );

  status_pin_mux #(.NPINS(NPINS), .MEM_LVL(4'b1110), .IO_LVL(4'b1111)) i_pins (
    .io_mode_i(io_mode_o),
    .pins_o   (pin_v)
  );

  assign wp_iois16_n_o   = pin_v[0];
  assign ready_ireq_n_o  = pin_v[1];
  assign bvd1_stschg_n_o = pin_v[2];
  assign bvd2_spkr_n_o   = pin_v[3];

  // R10: the mode follows the value of the last register write
  a_r10_mode_follows_write: assert property (@(posedge clk) disable iff (!rst_i)
    $past(cor_wr) |-> (io_mode_o == ($past(cor_wdata) != '0)));

  // R10: in I/O mode no shared pin sits low
  a_r10_io_pins_idle_high: assert property (@(posedge clk) disable iff (!rst_i)
    io_mode_o |-> (wp_iois16_n_o && ready_ireq_n_o && bvd1_stschg_n_o && bvd2_spkr_n_o));

endmodule

// File: tb/test_pccard_attr_resp.sv
`timescale 1ns/1ps
module test_pccard_attr_resp;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [25:0] addr;
  logic        ce1_n, ce2_n, oe_n, we_n, reg_n;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        doe;
  logic        p_wp, p_rdy, p_bvd1, p_bvd2, io_mode;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pccard_attr_resp i_pccard_attr_resp (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .ce1_n_i(ce1_n), .ce2_n_i(ce2_n),
    .oe_n_i(oe_n), .we_n_i(we_n), .reg_n_i(reg_n), .data_i(din),
    .data_o(dout), .data_oe_o(doe), .wp_iois16_n_o(p_wp),
    .ready_ireq_n_o(p_rdy), .bvd1_stschg_n_o(p_bvd1), .bvd2_spkr_n_o(p_bvd2),
    .io_mode_o(io_mode)
  );

  function automatic logic [7:0] exp_cis(input int n);
    logic [7:0] t [39] = '{8'h01, 8'h03, 8'hD4, 8'h00, 8'hFF,
      8'h15, 8'h0C, 8'h04, 8'h01, 8'h58, 8'h59, 8'h5A, 8'h00, 8'h50, 8'h43,
      8'h43, 8'h31, 8'h00, 8'hFF,
      8'h20, 8'h04, 8'hFF, 8'hFF, 8'h01, 8'h00,
      8'h1A, 8'h05, 8'h01, 8'h01, 8'h00, 8'h02, 8'h01,
      8'h1B, 8'h04, 8'hC1, 8'h01, 8'h08, 8'h26, 8'hFF};
    if (n < 39) return t[n];
    return 8'hFF;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ce1_n = 1'b1; ce2_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; reg_n = 1'b1;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // one read; returns data, drive flag and drive flag after OE# rises
  task automatic rd(input logic [25:0] a, input logic r_n, input logic c1_n,
                    input logic c2_n, output logic [7:0] d, output logic oe,
                    output logic oe_after);
    @(negedge clk);
    addr = a; reg_n = r_n; ce1_n = c1_n; ce2_n = c2_n; oe_n = 1'b0;
    cycles(2);
    d = dout; oe = doe;
    idle();
    cycles(2);
    oe_after = doe;
  endtask

  task automatic wr(input logic [25:0] a, input logic r_n, input logic [7:0] v);
    @(negedge clk);
    addr = a; reg_n = r_n; ce1_n = 1'b0; din = v; we_n = 1'b0;
    cycles(2);
    idle();
    cycles(2);
  endtask

  task automatic chk_pins(input string req, input logic io);
    chk(req, "io_mode", io_mode, io);
    chk(req, "pins {bvd2,bvd1,rdy,wp}", {p_bvd2, p_bvd1, p_rdy, p_wp},
        io ? 4'b1111 : 4'b1110);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic oe, oa;
    chk("R1", "drive during reset", doe, 1'b0);
    chk_pins("R1", 1'b0);
    @(negedge clk); rst_n = 1'b1;
    cycles(4);
    chk("R1", "drive after reset", doe, 1'b0);
    chk_pins("R1", 1'b0);
    rd(26'h200, 1'b0, 1'b0, 1'b1, d, oe, oa);
    chk("R1", "index after reset", d, 8'h00);
  endtask

  task automatic t_rom_walk();
    logic [7:0] d; logic oe, oa;
    for (int n = 0; n < 64; n++) begin
      rd(26'(2 * n), 1'b0, 1'b0, (n % 2 == 0), d, oe, oa);
      chk("R2", $sformatf("drive at ofs %0d", n), oe, 1'b1);
      if (n < 19)      chk("R4", $sformatf("byte ofs %0d", n), d, exp_cis(n));
      else if (n < 39) chk("R5", $sformatf("byte ofs %0d", n), d, exp_cis(n));
      else             chk("R6", $sformatf("byte ofs %0d", n), d, 8'hFF);
      chk("R7", $sformatf("release ofs %0d", n), oa, 1'b0);
    end
  endtask

  task automatic t_odd_and_beyond();
    logic [7:0] d; logic oe, oa;
    rd(26'h001, 1'b0, 1'b0, 1'b1, d, oe, oa); chk("R3", "odd 0x001", d, 8'h00);
    rd(26'h007, 1'b0, 1'b0, 1'b0, d, oe, oa); chk("R3", "odd 0x007", d, 8'h00);
    rd(26'h201, 1'b0, 1'b0, 1'b1, d, oe, oa); chk("R3", "odd 0x201", d, 8'h00);
    chk("R3", "odd drive", oe, 1'b1);
    rd(26'h080, 1'b0, 1'b0, 1'b1, d, oe, oa); chk("R6", "addr 0x080", d, 8'hFF);
    rd(26'h1FE, 1'b0, 1'b0, 1'b1, d, oe, oa); chk("R6", "addr 0x1FE", d, 8'hFF);
    rd(26'h3FFFFFE, 1'b0, 1'b0, 1'b1, d, oe, oa); chk("R6", "top addr", d, 8'hFF);
  endtask

  task automatic t_no_drive();
    logic [7:0] d; logic oe, oa;
    rd(26'h004, 1'b1, 1'b0, 1'b1, d, oe, oa); chk("R7", "REG# high read", oe, 1'b0);
    rd(26'h004, 1'b0, 1'b1, 1'b0, d, oe, oa); chk("R7", "CE1# high read", oe, 1'b0);
    rd(26'h004, 1'b0, 1'b0, 1'b0, d, oe, oa); chk("R2", "CE2# low read", d, 8'hD4);
  endtask

  task automatic t_config();
    logic [7:0] d; logic oe, oa;
    wr(26'h200, 1'b0, 8'hC1);
    rd(26'h200, 1'b0, 1'b0, 1'b1, d, oe, oa);
    chk("R8", "index from 0xC1", d, 8'h01);
    chk_pins("R10", 1'b1);
    wr(26'h200, 1'b1, 8'h00);
    chk_pins("R9", 1'b1);
    wr(26'h202, 1'b0, 8'h00);
    rd(26'h200, 1'b0, 1'b0, 1'b1, d, oe, oa);
    chk("R9", "index after stray writes", d, 8'h01);
    wr(26'h200, 1'b0, 8'h00);
    chk_pins("R10", 1'b0);
    wr(26'h200, 1'b0, 8'hFF);
    rd(26'h200, 1'b0, 1'b0, 1'b1, d, oe, oa);
    chk("R8", "index from 0xFF", d, 8'h3F);
    chk_pins("R10", 1'b1);
  endtask

  task automatic t_reset_in_io();
    logic [7:0] d; logic oe, oa;
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk_pins("R1", 1'b0);
    cycles(2);
    rst_n = 1'b1;
    cycles(4);
    rd(26'h200, 1'b0, 1'b0, 1'b1, d, oe, oa);
    chk("R1", "index after second reset", d, 8'h00);
    chk_pins("R1", 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; din = '0;
    idle();
    cycles(3);
    t_reset();
    t_rom_walk();
    t_odd_and_beyond();
    t_no_drive();
    t_config();
    t_reset_in_io();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule